// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block sits between a fast 8-bit processor core and a multiplexed external memory bus. Each request from the core becomes one external bus cycle: a code fetch, a data read or a data write. A cycle starts with an address phase. The address-latch strobe is high, the low address byte is on the shared port and the high byte is on the second port. In the data phase that follows, an active-low fetch, read or write strobe is asserted while the data moves on the shared port. The block returns a one-clock completion pulse and, for fetches and reads, the byte it captured.

The block is clocked at twice the rate of the core's input clock, so one tick is half an input period. A bus slot lasts 8 ticks, which is four input periods. Data cycles can be lengthened by a stretch count of whole slots so that slow peripherals have more time; fetches are never stretched. When no access is in progress, the latch strobe either runs continuously or is held quiet at a constant high level. A split page variant moves the data bus onto the high-address port and keeps the low address byte on the shared port for the whole cycle.

Top module: `emb_seq`

## Requirements
- R1: During and right after a synchronous reset, `ale_o` is 1. `psen_n_o`, `rd_n_o` and `wr_n_o` are 1, both port output enables are 0 and `done_o` is 0.
- R2: Every access shows the address while `ale_o` is high. On the tick `ale_o` falls, `p0_out_o`=addr[7:0] and `p2_out_o`=addr[15:8], with both enables set. When `ale_run_i`=1, the access's latch pulse lasts exactly 3 ticks (1.5 input clocks).
- R3: Once `ale_o` falls, the data port becomes the data bus. This is `p0` when `page_split_i`=0 and `p2` when it is 1. The port is released (enable 0) while a fetch or read strobe is low. It drives the write byte while `wr_n_o` is low.
- R4: `op_i` is encoded as 0 = fetch, 1 or 3 = read and 2 = write. A fetch pulses `psen_n_o` low for exactly 4 ticks and leaves `rd_n_o` and `wr_n_o` high. The stretch value has no effect on a fetch.
- R5: A read or write holds its strobe low for exactly 4+8*S ticks, where S is the stretch value. `ale_o` stays low for 5+8*S ticks, up to and including the `done_o` tick.
- R6: A stretch input above 10 is treated as 10.
- R7: With `ale_run_i`=0, `ale_o` is constantly high while idle.
- R8: With `ale_run_i`=1 and the block idle, `ale_o` is high 3 ticks of every 8.
- R9: At most one of `psen_n_o`, `rd_n_o` and `wr_n_o` is low at any time.
- R10: The written byte on the data port is stable for every tick that `wr_n_o` is low.
- R11: `done_o` is high for exactly one tick per access. For fetches and reads, `rdata_o` holds the byte that was on the data port at the last strobe tick.
- R12: With `page_split_i`=1, `p0_out_o` carries addr[7:0] for the whole access. The external memory sees the correct address and data over `p2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the core input clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, held until `done_o` |
| op_i | input | 2 | Access kind: 0 fetch, 1/3 read, 2 write |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write byte |
| stretch_i | input | 4 | Extra data slots, clamped to 10 |
| ale_run_i | input | 1 | 1: latch strobe runs while idle; 0: held high |
| page_split_i | input | 1 | 1: data on p2, low address held on p0 |
| done_o | output | 1 | One-tick completion pulse |
| rdata_o | output | 8 | Captured read or fetch byte |
| ale_o | output | 1 | Address latch strobe |
| psen_n_o | output | 1 | Program fetch strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| p0_out_o | output | 8 | Shared port drive value |
| p0_oe_o | output | 1 | Shared port drive enable |
| p0_in_i | input | 8 | Shared port sampled value |
| p2_out_o | output | 8 | High-address port drive value |
| p2_oe_o | output | 1 | High-address port drive enable |
| p2_in_i | input | 8 | High-address port sampled value |

## Verification
The embedded properties assume the core keeps its request and operands steady from request until the done pulse. They also assume `rst` is asserted at start-up. The write-stability property relies on the captured operands, not on the live inputs. The bench follows this handshake exactly: it changes operands only on the falling clock edge before raising `req_i`, and it drops the request on the tick `done_o` is seen. Stretch values 0 through 11 are swept in both port modes, which covers the clamp. The memory model returns a valid byte only while a fetch or read strobe is low, so any early sampling shows up as a wrong byte.

// File: rtl/emb_pkg.sv
package emb_pkg;
  typedef enum logic [1:0] {
    OP_FETCH = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READX = 2'd3
  } emb_op_e;

  typedef enum logic [1:0] {
    KIND_FETCH,
    KIND_READ,
    KIND_WRITE
  } emb_kind_e;

  function automatic emb_kind_e op_to_kind(input logic [1:0] op);
    case (op)
      2'd0:    op_to_kind = KIND_FETCH;
      2'd2:    op_to_kind = KIND_WRITE;
      default: op_to_kind = KIND_READ;
    endcase
  endfunction
endpackage

// File: rtl/emb_phase_gen.sv
module emb_phase_gen #(
  parameter int PHASES = 8,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase_o,
  output logic          last_o
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  always_ff @(posedge clk) begin
    if (rst || phase_o == LAST) phase_o <= '0;
    else                        phase_o <= phase_o + 1'b1;
  end

  assign last_o = (phase_o == LAST);

  a_r8_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase_o <= LAST);
endmodule

// File: rtl/emb_ctrl.sv
module emb_ctrl
  import emb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PHASES      = 8,
  parameter int ALE_TICKS   = 3,
  parameter int ADDR_TICKS  = 4,
  parameter int MAX_STRETCH = 10,
  parameter int STW         = 4,
  localparam int PW         = $clog2(PHASES),
  localparam int SW         = $clog2(MAX_STRETCH + 1),
  localparam int ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     phase_i,
  input  logic              last_i,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STW-1:0]    stretch_i,
  input  logic              ale_run_i,
  input  logic              page_split_i,
  output logic              busy_o,
  output logic              ale_dec_o,
  output logic              addr_dec_o,
  output logic              psen_dec_o,
  output logic              rd_dec_o,
  output logic              wr_dec_o,
  output logic              end_o,
  output logic              split_o,
  output logic              capture_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [PW-1:0] ALE_END  = PW'(ALE_TICKS);
  localparam logic [PW-1:0] ADDR_END = PW'(ADDR_TICKS);

  emb_kind_e   kind_q;
  logic [SW-1:0] len_q;
  logic [SW-1:0] slot_q;
  logic          accept;
  logic [SW-1:0] len_clamped;
  logic          first_slot;
  logic          strobe_dec;

  assign len_clamped = (stretch_i > STW'(MAX_STRETCH)) ? SW'(MAX_STRETCH)
                                                       : SW'(stretch_i);
  assign accept = !busy_o && req_i && last_i;
  assign end_o  = busy_o && (slot_q == len_q) && last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      slot_q  <= '0;
      len_q   <= '0;
      kind_q  <= KIND_FETCH;
      split_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept) begin
      busy_o  <= 1'b1;
      slot_q  <= '0;
      kind_q  <= op_to_kind(op_i);
      len_q   <= (op_to_kind(op_i) == KIND_FETCH) ? '0 : len_clamped;
      split_o <= page_split_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end else if (end_o) begin
      busy_o <= 1'b0;
    end else if (busy_o && last_i) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign first_slot = busy_o && (slot_q == '0);
  assign strobe_dec = busy_o && ((slot_q != '0) || (phase_i >= ADDR_END));

  always_comb begin
    if (busy_o)         ale_dec_o = first_slot && (phase_i < ALE_END);
    else if (ale_run_i) ale_dec_o = (phase_i < ALE_END);
    else                ale_dec_o = 1'b1;
  end

  assign addr_dec_o = first_slot && (phase_i < ADDR_END);
  assign psen_dec_o = strobe_dec && (kind_q == KIND_FETCH);
  assign rd_dec_o   = strobe_dec && (kind_q == KIND_READ);
  assign wr_dec_o   = strobe_dec && (kind_q == KIND_WRITE);
  assign capture_o  = end_o && (kind_q != KIND_WRITE);

  a_r6_len_clamped: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (len_q <= SW'(MAX_STRETCH)));
  a_r4_fetch_unstretched: assert property (@(posedge clk) disable iff (rst)
    (busy_o && kind_q == KIND_FETCH) |-> (slot_q == '0));
  a_r11_end_when_busy: assert property (@(posedge clk) disable iff (rst)
    end_o |=> !busy_o);
endmodule

// File: rtl/emb_pins.sv
module emb_pins #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              ale_dec_i,
  input  logic              addr_dec_i,
  input  logic              psen_dec_i,
  input  logic              rd_dec_i,
  input  logic              wr_dec_i,
  input  logic              end_i,
  input  logic              capture_i,
  input  logic              split_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] p0_out_o,
  output logic              p0_oe_o,
  input  logic [DATA_W-1:0] p0_in_i,
  output logic [DATA_W-1:0] p2_out_o,
  output logic              p2_oe_o,
  input  logic [DATA_W-1:0] p2_in_i
);
  logic [DATA_W-1:0] lo_byte, hi_byte;
  logic              bus_drive;

  assign lo_byte   = addr_i[DATA_W-1:0];
  assign hi_byte   = addr_i[ADDR_W-1:DATA_W];
  assign bus_drive = addr_dec_i || wr_dec_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o    <= 1'b1;
      psen_n_o <= 1'b1;
      rd_n_o   <= 1'b1;
      wr_n_o   <= 1'b1;
      done_o   <= 1'b0;
      rdata_o  <= '0;
      p0_out_o <= '0;
      p0_oe_o  <= 1'b0;
      p2_out_o <= '0;
      p2_oe_o  <= 1'b0;
    end else begin
      ale_o    <= ale_dec_i;
      psen_n_o <= !psen_dec_i;
      rd_n_o   <= !rd_dec_i;
      wr_n_o   <= !wr_dec_i;
      done_o   <= end_i;
      if (capture_i) rdata_o <= split_i ? p2_in_i : p0_in_i;
      if (split_i) begin
        p0_oe_o  <= busy_i;
        p0_out_o <= lo_byte;
        p2_oe_o  <= bus_drive;
        p2_out_o <= addr_dec_i ? hi_byte : wdata_i;
      end else begin
        p0_oe_o  <= bus_drive;
        p0_out_o <= addr_dec_i ? lo_byte : wdata_i;
        p2_oe_o  <= busy_i;
        p2_out_o <= hi_byte;
      end
    end
  end

  a_r1_ale_in_reset: assert property (@(posedge clk)
    rst |=> (ale_o && psen_n_o && rd_n_o && wr_n_o && !done_o));
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({!psen_n_o, !rd_n_o, !wr_n_o}) <= 1);
  a_r10_wdata_stable: assert property (@(posedge clk) disable iff (rst)
    (!wr_n_o && $past(!wr_n_o)) |-> ($stable(p0_out_o) && $stable(p2_out_o)));
  a_r3_released_on_read: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_o || !psen_n_o) |-> !(p0_oe_o && p2_oe_o));
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r2_no_strobe_with_ale: assert property (@(posedge clk) disable iff (rst)
    !(ale_o && (!psen_n_o || !rd_n_o || !wr_n_o)));
endmodule

// File: rtl/emb_seq.sv
module emb_seq #(
  parameter int DATA_W      = 8,
  parameter int PHASES      = 8,
  parameter int ALE_TICKS   = 3,
  parameter int ADDR_TICKS  = 4,
  parameter int MAX_STRETCH = 10,
  parameter int STW         = 4,
  localparam int ADDR_W     = 2 * DATA_W,
  localparam int PW         = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STW-1:0]    stretch_i,
  input  logic              ale_run_i,
  input  logic              page_split_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] p0_out_o,
  output logic              p0_oe_o,
  input  logic [DATA_W-1:0] p0_in_i,
  output logic [DATA_W-1:0] p2_out_o,
  output logic              p2_oe_o,
  input  logic [DATA_W-1:0] p2_in_i
);
  logic [PW-1:0]     phase;
  logic              last_phase;
  logic              busy, ale_dec, addr_dec, psen_dec, rd_dec, wr_dec;
  logic              end_acc, split, capture;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  emb_phase_gen #(.PHASES(PHASES)) phase_i (
    .clk(clk), .rst(rst), .phase_o(phase), .last_o(last_phase)
  );

  emb_ctrl #(
    .DATA_W(DATA_W), .PHASES(PHASES), .ALE_TICKS(ALE_TICKS),
    .ADDR_TICKS(ADDR_TICKS), .MAX_STRETCH(MAX_STRETCH), .STW(STW)
  ) ctrl_i (
    .clk(clk), .rst(rst), .phase_i(phase), .last_i(last_phase),
    .req_i(req_i), .op_i(op_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .stretch_i(stretch_i), .ale_run_i(ale_run_i), .page_split_i(page_split_i),
    .busy_o(busy), .ale_dec_o(ale_dec), .addr_dec_o(addr_dec),
    .psen_dec_o(psen_dec), .rd_dec_o(rd_dec), .wr_dec_o(wr_dec),
    .end_o(end_acc), .split_o(split), .capture_o(capture),
    .addr_o(addr_q), .wdata_o(wdata_q)
  );

  emb_pins #(.DATA_W(DATA_W)) pins_i (
    .clk(clk), .rst(rst), .busy_i(busy), .ale_dec_i(ale_dec),
    .addr_dec_i(addr_dec), .psen_dec_i(psen_dec), .rd_dec_i(rd_dec),
    .wr_dec_i(wr_dec), .end_i(end_acc), .capture_i(capture), .split_i(split),
    .addr_i(addr_q), .wdata_i(wdata_q), .done_o(done_o), .rdata_o(rdata_o),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .p0_out_o(p0_out_o), .p0_oe_o(p0_oe_o), .p0_in_i(p0_in_i),
    .p2_out_o(p2_out_o), .p2_oe_o(p2_oe_o), .p2_in_i(p2_in_i)
  );
endmodule

// File: tb/emb_seq_tb.sv
module emb_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  stretch = '0;
  logic        ale_run = 1'b0;
  logic        split = 1'b0;
  logic        done, ale, psen_n, rd_n, wr_n, p0_oe, p2_oe;
  logic [7:0]  rdata, p0_out, p2_out, p0_in, p2_in;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  emb_seq dut_i (
    .clk(clk), .rst(rst), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .stretch_i(stretch), .ale_run_i(ale_run),
    .page_split_i(split), .done_o(done), .rdata_o(rdata), .ale_o(ale),
    .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .p0_out_o(p0_out),
    .p0_oe_o(p0_oe), .p0_in_i(p0_in), .p2_out_o(p2_out), .p2_oe_o(p2_oe),
    .p2_in_i(p2_in)
  );

  // External memory model: latches the address on the falling latch strobe
  logic [7:0]  mem [256];
  logic [15:0] lat = '0;
  logic        m_prev_ale = 1'b1;
  logic        wr_pend = 1'b0;
  logic [7:0]  wbuf = '0;
  logic        m_drive;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);

  always @(negedge clk) begin
    if (m_prev_ale && !ale) lat <= {p2_out, p0_out};
    m_prev_ale <= ale;
    if (!wr_n) begin
      wbuf    <= split ? p2_out : p0_out;
      wr_pend <= 1'b1;
    end else if (wr_pend) begin
      mem[lat[7:0]] <= wbuf;
      wr_pend       <= 1'b0;
    end
  end

  assign m_drive = !rd_n || !psen_n;
  assign p0_in = (m_drive && !split) ? mem[lat[7:0]] : 8'hFF;
  assign p2_in = (m_drive &&  split) ? mem[lat[7:0]] : 8'hFF;

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic do_access(input logic [1:0] o, input logic [15:0] a,
                           input logic [7:0] wd, input int st, input bit sp);
    int hi_run = 0, lo_run = 0, last_hi = 0, psen_lo = 0, rd_lo = 0, wr_lo = 0;
    int bad_bus = 0, conflict = 0, ticks = 0, slen;
    bit prev_a = 1'b1, fall_ok = 1'b0, split_lo_ok = 1'b1;
    logic [7:0] exp_rd;
    slen = (o == 2'd0) ? 0 : ((st > 10) ? 10 : st);
    @(negedge clk);
    op = o; addr = a; wdata = wd; stretch = 4'(st); split = sp; req = 1'b1;
    exp_rd = mem[a[7:0]];
    forever begin
      @(negedge clk);
      ticks++;
      if (ale) begin
        hi_run = prev_a ? hi_run + 1 : 1;
        lo_run = 0;
      end else begin
        if (prev_a) begin
          last_hi = hi_run;
          fall_ok = p0_oe && p2_oe && p0_out == a[7:0] && p2_out == a[15:8];
        end
        lo_run++;
      end
      prev_a = ale;
      if (!psen_n) psen_lo++;
      if (!rd_n)   rd_lo++;
      if (!wr_n)   wr_lo++;
      if ($countones({!psen_n, !rd_n, !wr_n}) > 1) conflict++;
      if (!wr_n && !(sp ? (p2_oe && p2_out == wd) : (p0_oe && p0_out == wd))) bad_bus++;
      if ((!rd_n || !psen_n) && (sp ? p2_oe : p0_oe)) bad_bus++;
      if (sp && (p2_oe || !psen_n || !rd_n || !wr_n) && !(p0_oe && p0_out == a[7:0]))
        split_lo_ok = 1'b0;
      if (done || ticks > 400) break;
    end
    req = 1'b0;
    chk(ticks <= 400, "R11 watchdog", ticks, 400);
    chk(fall_ok, "R2 address on ports at latch fall", fall_ok, 1);
    if (ale_run) chk(last_hi == 3, "R2 latch pulse width", last_hi, 3);
    chk(lo_run == 5 + 8 * slen, "R5 latch low span", lo_run, 5 + 8 * slen);
    chk(conflict == 0, "R9 strobe exclusion", conflict, 0);
    chk(bad_bus == 0, "R3 R10 data port drive", bad_bus, 0);
    if (o == 2'd0) begin
      chk(psen_lo == 4 && rd_lo == 0 && wr_lo == 0, "R4 fetch strobe", psen_lo, 4);
      chk(rdata == exp_rd, "R11 fetch data", rdata, exp_rd);
    end else if (o == 2'd2) begin
      chk(wr_lo == 4 + 8 * slen && psen_lo == 0 && rd_lo == 0,
          st > 10 ? "R6 clamped write strobe" : "R5 write strobe", wr_lo, 4 + 8 * slen);
    end else begin
      chk(rd_lo == 4 + 8 * slen && psen_lo == 0 && wr_lo == 0,
          st > 10 ? "R6 clamped read strobe" : "R5 read strobe", rd_lo, 4 + 8 * slen);
      chk(rdata == exp_rd, "R11 read data", rdata, exp_rd);
    end
    if (sp) chk(split_lo_ok, "R12 low address held on p0", split_lo_ok, 1);
    @(negedge clk);
    chk(!done, "R11 done single tick", done, 0);
    @(negedge clk);
    if (o == 2'd2) chk(mem[a[7:0]] == wd, "R12 R3 written byte", mem[a[7:0]], wd);
  endtask

  task automatic idle_watch(input int exp_hi, input string tag);
    int hi = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (ale) hi++;
    end
    chk(hi == exp_hi, tag, hi, exp_hi);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(ale && psen_n && rd_n && wr_n && !p0_oe && !p2_oe && !done,
        "R1 outputs in reset", ale, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(ale && psen_n && rd_n && wr_n && !p0_oe && !p2_oe && !done,
        "R1 outputs after reset", ale, 1);
    ale_run = 1'b0;
    idle_watch(32, "R7 quiet idle latch");
    ale_run = 1'b1;
    idle_watch(12, "R8 running idle latch");
    for (int sp = 0; sp < 2; sp++) begin
      for (int st = 0; st < 12; st++) begin
        ale_run = st[0];
        do_access(2'd2, {4'(st), 3'(sp), 9'(st * 19 + 5)}, 8'(st * 29 + sp * 77 + 1), st, sp[0]);
        do_access(2'(1 + 2 * (st % 2 == 1 ? 1 : 0)), {4'(st), 3'(sp), 9'(st * 19 + 5)},
                  8'(st * 29 + sp * 77 + 1), st, sp[0]);
      end
      do_access(2'd0, 16'h4C00 + 16'(sp * 33), 8'h00, 9, sp[0]);
      do_access(2'd0, 16'h00FE, 8'h00, 15, sp[0]);
    end
    ale_run = 1'b0;
    idle_watch(32, "R7 quiet idle after traffic");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL R11 watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule